// File: doc/BRIEF.md
# Word-Indexed Transfer Buffer With Host and Stream Ports

This block holds the payload of one serial-flash transfer: 512 bytes arranged as 128 words of 32 bits. A host reaches the storage indirectly through two registers. The configuration register selects which way the data flows, whether the word pointer steps by itself, and where that pointer starts. The data register moves one whole word per access.

On the other side, a serial sequencer streams single bytes in or out. Before each transfer it loads its own byte start position, which is normally zero. Bytes are packed little-endian. Host and sequencer may touch the storage in the same cycle, and the block defines exactly what results.

A host tail of one to three bytes is still moved as a full word access. Only the low-order bytes of that word carry meaning.

Top module: `tbuf_xfer_port`

## Requirements
- R1: After reset, every stored word is zero, the configuration reads back as zero, and both read outputs are zero.
- R2: A host write with `hst_reg`=0 loads the configuration: bit 31 is the direction (1 means the host fills the buffer), bit 30 turns automatic pointer stepping on, and bits 6:0 set the word pointer. Bit 7 of the address field is ignored. A configuration read returns these fields in the same positions, with every other bit zero.
- R3: With direction 1, a host write with `hst_reg`=1 stores the full 32-bit word at the word pointer.
- R4: With stepping on, each data access that matches the direction moves the word pointer up by one, and word 127 wraps to word 0.
- R5: With stepping off, repeated data accesses all address the same word, and the pointer does not change.
- R6: A data access against the direction leaves the pointer alone. A write while direction is 0 stores nothing. A read while direction is 1 still returns the word.
- R7: A host read returns its value on `hst_rdata` one cycle after the access. `hst_rdata` holds its value in every cycle with no host read.
- R8: A start-position load sets the sequencer byte pointer. A byte write or read requested in the same cycle is dropped.
- R9: A sequencer byte write stores into byte index b, which is word b/4 at bits 8*(b mod 4)+7 down to 8*(b mod 4). The pointer then steps by one, and byte 511 wraps to byte 0.
- R10: A sequencer byte read returns the addressed byte on `seq_rbyte` one cycle later and steps the pointer. If write and read are both requested, only the write happens, and `seq_rbyte` holds.
- R11: When a host word write and a sequencer byte write hit the same word in one cycle, the sequencer's byte lane comes from the sequencer, and the other three lanes come from the host.
- R12: A read in the same cycle as a write to the same word returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_sel | input | 1 | Host access strobe |
| hst_we | input | 1 | Host access is a write |
| hst_reg | input | 1 | 0 selects the configuration register, 1 selects the data register |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, registered |
| seq_start_we | input | 1 | Load the sequencer byte start position |
| seq_start_addr | input | 9 | Byte start position |
| seq_wr | input | 1 | Sequencer byte write |
| seq_rd | input | 1 | Sequencer byte read |
| seq_wbyte | input | 8 | Byte to store |
| seq_rbyte | output | 8 | Byte read, registered |

## Verification
Host access and sequencer streaming can land on the same word in the same cycle. Two cases matter: a host word write coinciding with a sequencer byte write, and a host word read coinciding with a sequencer byte write. The bench sets both pointers to the same word and raises both strobes at once. It then judges the merged word, and the value returned from before the write, against a behavioural model that applies the host word first and the sequencer byte over it.

// File: rtl/tbuf_pkg.sv
package tbuf_pkg;

    parameter int BUF_BYTES  = 512;
    parameter int WORD_BYTES = 4;
    parameter int WORD_W     = 8 * WORD_BYTES;
    parameter int WORDS      = BUF_BYTES / WORD_BYTES;
    parameter int WPTR_W     = $clog2(WORDS);
    parameter int BPTR_W     = $clog2(BUF_BYTES);
    parameter int LANE_W     = $clog2(WORD_BYTES);
    parameter int DIR_BIT    = 31;
    parameter int AUTO_BIT   = 30;

    typedef enum logic {
        REG_CFG  = 1'b0,
        REG_DATA = 1'b1
    } hreg_e;

    typedef struct packed {
        logic              en;
        logic [WPTR_W-1:0] idx;
        logic [WORD_W-1:0] data;
    } word_wr_t;

    typedef struct packed {
        logic              en;
        logic [BPTR_W-1:0] pos;
        logic [7:0]        data;
    } byte_wr_t;

    function automatic logic [WPTR_W-1:0] word_of(input logic [BPTR_W-1:0] pos);
        return pos[BPTR_W-1:LANE_W];
    endfunction

    function automatic logic [LANE_W-1:0] lane_of(input logic [BPTR_W-1:0] pos);
        return pos[LANE_W-1:0];
    endfunction

endpackage

// File: rtl/tbuf_host_port.sv
module tbuf_host_port
    import tbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              we,
    input  hreg_e             rsel,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] cur_word,
    output logic [WORD_W-1:0] rdata,
    output logic [WPTR_W-1:0] ptr,
    output logic              dir,
    output logic              auto_inc,
    output word_wr_t          wr
);
    localparam int PAD_W = WORD_W - 2 - WPTR_W;

    logic data_acc;
    logic dir_match;
    logic cfg_load;
    logic [WORD_W-1:0] cfg_view;

    assign data_acc  = sel && (rsel == REG_DATA);
    assign dir_match = data_acc && (we == dir);
    assign cfg_load  = sel && we && (rsel == REG_CFG);
    assign cfg_view  = {dir, auto_inc, {PAD_W{1'b0}}, ptr};

    always_comb begin
        wr.en   = data_acc && we && dir;
        wr.idx  = ptr;
        wr.data = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir      <= 1'b0;
            auto_inc <= 1'b0;
            ptr      <= '0;
            rdata    <= '0;
        end else begin
            if (cfg_load) begin
                dir      <= wdata[DIR_BIT];
                auto_inc <= wdata[AUTO_BIT];
                ptr      <= wdata[WPTR_W-1:0];
            end else if (dir_match && auto_inc) begin
                ptr <= ptr + 1'b1;
            end
            if (sel && !we) begin
                rdata <= (rsel == REG_DATA) ? cur_word : cfg_view;
            end
        end
    end
endmodule

// File: rtl/tbuf_seq_port.sv
module tbuf_seq_port
    import tbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_we,
    input  logic [BPTR_W-1:0] start_pos,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [7:0]        wbyte,
    input  logic [WORD_W-1:0] cur_word,
    output logic [BPTR_W-1:0] pos,
    output logic [7:0]        rbyte,
    output byte_wr_t          wr
);
    logic do_wr;
    logic do_rd;

    assign do_wr = wr_req && !start_we;
    assign do_rd = rd_req && !wr_req && !start_we;

    always_comb begin
        wr.en   = do_wr;
        wr.pos  = pos;
        wr.data = wbyte;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos   <= '0;
            rbyte <= '0;
        end else begin
            if (start_we) begin
                pos <= start_pos;
            end else if (do_wr || do_rd) begin
                pos <= pos + 1'b1;
            end
            if (do_rd) begin
                rbyte <= cur_word[8*lane_of(pos) +: 8];
            end
        end
    end
endmodule

// File: rtl/tbuf_store.sv
module tbuf_store
    import tbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  word_wr_t          hwr,
    input  byte_wr_t          swr,
    input  logic [WPTR_W-1:0] h_idx,
    input  logic [WPTR_W-1:0] s_idx,
    output logic [WORD_W-1:0] h_word,
    output logic [WORD_W-1:0] s_word
);
    logic [WORD_W-1:0] mem [WORDS];

    assign h_word = mem[h_idx];
    assign s_word = mem[s_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WORDS; w++) begin
                mem[w] <= '0;
            end
        end else begin
            if (hwr.en) begin
                mem[hwr.idx] <= hwr.data;
            end
            if (swr.en) begin
                mem[word_of(swr.pos)][8*lane_of(swr.pos) +: 8] <= swr.data;
            end
        end
    end
endmodule

// File: rtl/tbuf_xfer_port.sv
module tbuf_xfer_port
    import tbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_sel,
    input  logic              hst_we,
    input  logic              hst_reg,
    input  logic [31:0]       hst_wdata,
    output logic [31:0]       hst_rdata,
    input  logic              seq_start_we,
    input  logic [8:0]        seq_start_addr,
    input  logic              seq_wr,
    input  logic              seq_rd,
    input  logic [7:0]        seq_wbyte,
    output logic [7:0]        seq_rbyte
);
    word_wr_t          h_wr;
    byte_wr_t          s_wr;
    logic [WPTR_W-1:0] w_ptr;
    logic [BPTR_W-1:0] b_ptr;
    logic [WORD_W-1:0] h_word;
    logic [WORD_W-1:0] s_word;
    logic              cfg_dir;
    logic              cfg_auto;
    hreg_e             rsel;

    assign rsel = hreg_e'(hst_reg);

    tbuf_host_port u_host (
        .clk      (clk),
        .rst      (rst),
        .sel      (hst_sel),
        .we       (hst_we),
        .rsel     (rsel),
        .wdata    (hst_wdata),
        .cur_word (h_word),
        .rdata    (hst_rdata),
        .ptr      (w_ptr),
        .dir      (cfg_dir),
        .auto_inc (cfg_auto),
        .wr       (h_wr)
    );

    tbuf_seq_port u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_we  (seq_start_we),
        .start_pos (seq_start_addr),
        .wr_req    (seq_wr),
        .rd_req    (seq_rd),
        .wbyte     (seq_wbyte),
        .cur_word  (s_word),
        .pos       (b_ptr),
        .rbyte     (seq_rbyte),
        .wr        (s_wr)
    );

    tbuf_store u_store (
        .clk    (clk),
        .rst    (rst),
        .hwr    (h_wr),
        .swr    (s_wr),
        .h_idx  (w_ptr),
        .s_idx  (word_of(b_ptr)),
        .h_word (h_word),
        .s_word (s_word)
    );
endmodule

// File: rtl/tbuf_xfer_port_chk.sv
module tbuf_xfer_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        hst_sel,
    input logic        hst_we,
    input logic        hst_reg,
    input logic [31:0] hst_rdata,
    input logic        seq_start_we,
    input logic [8:0]  seq_start_addr,
    input logic        seq_wr,
    input logic        seq_rd,
    input logic [7:0]  seq_rbyte,
    input logic [6:0]  w_ptr,
    input logic [8:0]  b_ptr,
    input logic        cfg_dir,
    input logic        cfg_auto
);
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(hst_sel && !hst_we) |=> $stable(hst_rdata)); // R7

    AST_RBYTE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(seq_rd && !seq_wr && !seq_start_we) |=> $stable(seq_rbyte)); // R10

    AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
        seq_start_we |=> (b_ptr == $past(seq_start_addr))); // R8

    AST_STREAM_STEP: assert property (@(posedge clk) disable iff (rst)
        (!seq_start_we && (seq_wr || seq_rd)) |=> (b_ptr == $past(b_ptr) + 9'd1)); // R9

    AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (hst_sel && hst_reg && !cfg_auto) |=> $stable(w_ptr)); // R5

    AST_WRONG_DIR: assert property (@(posedge clk) disable iff (rst)
        (hst_sel && hst_reg && (hst_we != cfg_dir)) |=> $stable(w_ptr)); // R6
endmodule

bind tbuf_xfer_port tbuf_xfer_port_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .hst_sel        (hst_sel),
    .hst_we         (hst_we),
    .hst_reg        (hst_reg),
    .hst_rdata      (hst_rdata),
    .seq_start_we   (seq_start_we),
    .seq_start_addr (seq_start_addr),
    .seq_wr         (seq_wr),
    .seq_rd         (seq_rd),
    .seq_rbyte      (seq_rbyte),
    .w_ptr          (w_ptr),
    .b_ptr          (b_ptr),
    .cfg_dir        (cfg_dir),
    .cfg_auto       (cfg_auto)
);

// File: tb/tbuf_xfer_port_tb.sv
module tbuf_xfer_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hst_sel = 1'b0, hst_we = 1'b0, hst_reg = 1'b0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        seq_start_we = 1'b0, seq_wr = 1'b0, seq_rd = 1'b0;
    logic [8:0]  seq_start_addr = '0;
    logic [7:0]  seq_wbyte = '0;
    logic [7:0]  seq_rbyte;

    int    n_chk = 0;
    int    n_err = 0;
    string cur_tag = "R1";

    logic [31:0] m_mem [0:127];
    logic [6:0]  m_ptr;
    logic [8:0]  m_bptr;
    logic        m_dir, m_auto;
    logic [31:0] m_rdata;
    logic [7:0]  m_rbyte;

    always #10 clk = ~clk;

    tbuf_xfer_port u_dut (
        .clk(clk), .rst(rst),
        .hst_sel(hst_sel), .hst_we(hst_we), .hst_reg(hst_reg),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .seq_start_we(seq_start_we), .seq_start_addr(seq_start_addr),
        .seq_wr(seq_wr), .seq_rd(seq_rd), .seq_wbyte(seq_wbyte),
        .seq_rbyte(seq_rbyte)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        bit          hw_en = 0, sw_en = 0;
        int          hw_idx = 0, sw_pos = 0;
        logic [31:0] hw_word = '0;
        logic [7:0]  sw_d = '0;
        if (rst) begin
            for (int i = 0; i < 128; i++) m_mem[i] = '0;
            m_ptr = '0; m_bptr = '0; m_dir = 0; m_auto = 0; m_rdata = '0; m_rbyte = '0;
        end else begin
            if (hst_sel) begin
                if (!hst_we) begin
                    m_rdata = hst_reg ? m_mem[m_ptr] : {m_dir, m_auto, 23'd0, m_ptr};
                    if (hst_reg && !m_dir && m_auto) m_ptr = m_ptr + 1;
                end else if (!hst_reg) begin
                    m_dir = hst_wdata[31]; m_auto = hst_wdata[30]; m_ptr = hst_wdata[6:0];
                end else if (m_dir) begin
                    hw_en = 1; hw_idx = int'(m_ptr); hw_word = hst_wdata;
                    if (m_auto) m_ptr = m_ptr + 1;
                end
            end
            if (seq_start_we) begin
                m_bptr = seq_start_addr;
            end else if (seq_wr) begin
                sw_en = 1; sw_pos = int'(m_bptr); sw_d = seq_wbyte; m_bptr = m_bptr + 1;
            end else if (seq_rd) begin
                m_rbyte = m_mem[m_bptr / 4][8 * (m_bptr % 4) +: 8];
                m_bptr = m_bptr + 1;
            end
            if (hw_en) m_mem[hw_idx] = hw_word;
            if (sw_en) m_mem[sw_pos / 4][8 * (sw_pos % 4) +: 8] = sw_d;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({cur_tag, " host read port"}, hst_rdata, m_rdata);
        chk({cur_tag, " stream read port"}, {24'd0, seq_rbyte}, {24'd0, m_rbyte});
    endtask

    task automatic idle();
        hst_sel = 0; hst_we = 0; hst_reg = 0; hst_wdata = '0;
        seq_start_we = 0; seq_wr = 0; seq_rd = 0; seq_wbyte = '0; seq_start_addr = '0;
    endtask

    task automatic hwr(input logic r, input logic [31:0] d);
        hst_sel = 1; hst_we = 1; hst_reg = r; hst_wdata = d;
        step(); idle();
    endtask

    task automatic hrd(input logic r, input string tag, input logic [31:0] exp);
        hst_sel = 1; hst_we = 0; hst_reg = r;
        step(); idle();
        chk(tag, hst_rdata, exp);
    endtask

    task automatic sstart(input logic [8:0] a);
        seq_start_we = 1; seq_start_addr = a;
        step(); idle();
    endtask

    task automatic swr(input logic [7:0] b);
        seq_wr = 1; seq_wbyte = b;
        step(); idle();
    endtask

    task automatic srd(input string tag, input logic [7:0] exp);
        seq_rd = 1;
        step(); idle();
        chk(tag, {24'd0, seq_rbyte}, {24'd0, exp});
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(); step();
        rst = 0;
        // R1: reset state
        cur_tag = "R1";
        chk("R1 stream byte after reset", {24'd0, seq_rbyte}, 32'd0);
        hrd(1'b0, "R1 cfg after reset", 32'h0000_0000);
        hrd(1'b1, "R1 word 0 after reset", 32'h0000_0000);

        // R2: configuration fields, bit 7 of pointer ignored
        cur_tag = "R2";
        hwr(1'b0, 32'hC000_00FF);
        hrd(1'b0, "R2 cfg readback", 32'hC000_007F);

        // R3 / R4: fill with wrap
        cur_tag = "R4";
        hwr(1'b0, 32'hC000_007E);
        hwr(1'b1, 32'h1111_1111);
        hwr(1'b1, 32'h2222_2222);
        hwr(1'b1, 32'h3333_3333);
        hrd(1'b0, "R4 pointer wrapped", 32'hC000_0001);
        cur_tag = "R7";
        hwr(1'b0, 32'h4000_007E);
        hrd(1'b1, "R3 word 126", 32'h1111_1111);
        hrd(1'b1, "R3 word 127", 32'h2222_2222);
        hrd(1'b1, "R7 word 0 after wrap", 32'h3333_3333);
        hrd(1'b0, "R4 read pointer", 32'h4000_0001);

        // R5: stepping off
        cur_tag = "R5";
        hwr(1'b0, 32'h8000_000A);
        hwr(1'b1, 32'hA5A5_A5A5);
        hwr(1'b1, 32'h5A5A_5A5A);
        hwr(1'b0, 32'h0000_000A);
        hrd(1'b1, "R5 same word first", 32'h5A5A_5A5A);
        hrd(1'b1, "R5 same word second", 32'h5A5A_5A5A);
        hrd(1'b0, "R5 pointer held", 32'h0000_000A);

        // R6: accesses against the direction
        cur_tag = "R6";
        hwr(1'b0, 32'h4000_000A);
        hwr(1'b1, 32'hDEAD_BEEF);
        hrd(1'b0, "R6 write ignored pointer", 32'h4000_000A);
        hrd(1'b1, "R6 write ignored data", 32'h5A5A_5A5A);
        hwr(1'b0, 32'hC000_000A);
        hrd(1'b1, "R6 read while filling", 32'h5A5A_5A5A);
        hrd(1'b0, "R6 read did not step", 32'hC000_000A);

        // R9: stream writes, packing and wrap
        cur_tag = "R9";
        sstart(9'h1FE);
        swr(8'hA1); swr(8'hA2); swr(8'hA3); swr(8'hA4);
        hwr(1'b0, 32'h4000_007F);
        hrd(1'b1, "R9 word 127 lanes", 32'hA2A1_2222);
        hrd(1'b1, "R9 word 0 lanes", 32'h3333_A4A3);

        // R10: stream reads, write wins over read
        cur_tag = "R10";
        sstart(9'd0);
        srd("R10 byte 0", 8'hA3);
        srd("R10 byte 1", 8'hA4);
        srd("R10 byte 2", 8'h33);
        srd("R10 byte 3", 8'h33);
        seq_wr = 1; seq_rd = 1; seq_wbyte = 8'h77;
        step(); idle();
        chk("R10 read dropped under write", {24'd0, seq_rbyte}, 32'h33);
        srd("R10 byte 5", 8'h00);
        sstart(9'd4);
        srd("R10 byte 4 written", 8'h77);

        // R8: start load drops same-cycle write
        cur_tag = "R8";
        seq_start_we = 1; seq_start_addr = 9'h1FE; seq_wr = 1; seq_wbyte = 8'hEE;
        step(); idle();
        srd("R8 load and write dropped", 8'hA1);

        // R11: same-word write collision
        cur_tag = "R11";
        hwr(1'b0, 32'h8000_0014);
        sstart(9'd81);
        hst_sel = 1; hst_we = 1; hst_reg = 1; hst_wdata = 32'hAABB_CCDD;
        seq_wr = 1; seq_wbyte = 8'h11;
        step(); idle();
        hwr(1'b0, 32'h0000_0014);
        hrd(1'b1, "R11 merged word", 32'hAABB_11DD);

        // R12: read sees value from before same-cycle write
        cur_tag = "R12";
        sstart(9'd80);
        hst_sel = 1; hst_we = 0; hst_reg = 1;
        seq_wr = 1; seq_wbyte = 8'h99;
        step(); idle();
        chk("R12 old value returned", hst_rdata, 32'hAABB_11DD);
        hrd(1'b1, "R12 new value visible", 32'hAABB_1199);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule